// File: doc/BRIEF.md
# GPIO Expander Register Bank

This block is the configuration and data store behind a 16-line general-purpose I/O expander. A serial-bus slave front end (not part of this block) turns bus transactions into single-byte register writes and reads on a plain address/data port. The bank keeps per-line settings for pull-up, pull-down, open-drain drive, polarity inversion, direction, output level, interrupt mask and edge sense. It also holds a clock-pin control byte and a miscellaneous byte, and it turns these settings into pad output, pad output-enable and pull controls.

Each per-line setting takes two consecutive bytes. The higher address holds lines 0 to 7 and the address just below it holds lines 8 to 15, so the bytes for higher-numbered lines sit lower in the map. Two-bit fields are packed the same way and take four bytes. Pad inputs pass through a synchronizer and are then read back through the data address, after the polarity setting is applied. A fixed two-byte key written to the reset address puts every register back to its power-up value.

Top module: `gx_regbank`

## Requirements
- R1: After a hardware reset the direction bytes (0x0E, 0x0F) and the mask bytes (0x12, 0x13) read 0xFF, every other register reads 0x00, pad_oe is all zeros and osc_oe is 0.
- R2: A one-bit-per-line register with base address N stores lines 0 to 7 at N and lines 8 to 15 at N-1, and reads back what was written. The bases are: pull-up 0x07, pull-down 0x09, open-drain 0x0B, polarity 0x0D, direction 0x0F, mask 0x13. The misc byte sits at 0x1F and reads back what was written.
- R3: The two-bit sense field of line k sits at address 0x17 - k/4, bits 2*(k%4)+1 down to 2*(k%4), so the four bytes 0x14 to 0x17 store and read back independently.
- R4: A direction bit of 1 makes its line an input (pad_oe low). A direction bit of 0 makes it an output, and pad_oe is high when the line is push-pull.
- R5: The data bytes (base 0x11) set the driven level, and pad_out[k] equals data[k] XOR polarity[k] for push-pull lines.
- R6: Reading the data bytes returns the synchronized pad_in XOR polarity. A pad change becomes visible after the second rising clock edge and not after the first.
- R7: When the open-drain bit of a line is set, pad_out is 0 and pad_oe is high only while the line's level (data XOR polarity) is 0.
- R8: Writing 0x1F to the clock byte 0x1E sets osc_oe=1 and osc_out=1. Writing 0x10 sets osc_oe=1 and osc_out=0. osc_oe follows bit 4 of the byte, and osc_out is high only when bits 4 to 0 are all ones.
- R9: Writing 0x12 and then 0x34 as consecutive writes to address 0x7D returns all registers to their R1 values from the next cycle on.
- R10: Any other write between 0x12 and 0x34 cancels the armed key, so the later 0x34 has no effect and the intervening write takes effect normally.
- R11: The reset address 0x7D, the interrupt source bytes 0x18 and 0x19, and unmapped addresses read 0x00. Writes to unmapped addresses change nothing.
- R12: The pad_pu and pad_pd outputs equal the pull-up and pull-down registers bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe for one cycle |
| addr | input | 8 | Register address for both write and read |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte for addr, combinational |
| pad_in | input | NL | Raw pad input levels |
| pad_out | output | NL | Pad output level |
| pad_oe | output | NL | Pad output enable |
| pad_pu | output | NL | Pull-up enables |
| pad_pd | output | NL | Pull-down enables |
| osc_out | output | 1 | Clock pin level when used as output |
| osc_oe | output | 1 | Clock pin output enable |

## Verification
The bench builds the bank with its defaults, NL=16 and SYNC_STAGES=2. With these values both bytes of every per-line setting, all four sense bytes and the downward byte order can be reached at their real addresses. The two-stage synchronizer lets the bench check the exact cycle in which a pad change first shows in the data read. The open-drain, polarity and direction cases are set up on the low byte, and the high byte stays input so it can show that lines are independent.

// File: rtl/gx_pkg.sv
package gx_pkg;
    localparam logic [7:0] A_PU   = 8'h07;
    localparam logic [7:0] A_PD   = 8'h09;
    localparam logic [7:0] A_OD   = 8'h0B;
    localparam logic [7:0] A_POL  = 8'h0D;
    localparam logic [7:0] A_DIR  = 8'h0F;
    localparam logic [7:0] A_DAT  = 8'h11;
    localparam logic [7:0] A_MSK  = 8'h13;
    localparam logic [7:0] A_SNS  = 8'h17;
    localparam logic [7:0] A_CLK  = 8'h1E;
    localparam logic [7:0] A_MISC = 8'h1F;
    localparam logic [7:0] A_RST  = 8'h7D;
    localparam logic [7:0] KEY_1  = 8'h12;
    localparam logic [7:0] KEY_2  = 8'h34;
endpackage

// File: rtl/gx_sync.sv
module gx_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= din;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/gx_regfile.sv
module gx_regfile
    import gx_pkg::*;
#(
    parameter int NL = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    addr,
    input  logic [7:0]    wr_data,
    input  logic [NL-1:0] pin_sync,
    output logic [7:0]    rd_data,
    output logic [NL-1:0] pu,
    output logic [NL-1:0] pd,
    output logic [NL-1:0] od,
    output logic [NL-1:0] pol,
    output logic [NL-1:0] dir,
    output logic [NL-1:0] dat,
    output logic [7:0]    clk_cfg
);
    localparam int NB  = NL / 8;
    localparam int NSB = 2 * NL / 8;

    typedef struct packed {
        logic [NL-1:0]   pu;
        logic [NL-1:0]   pd;
        logic [NL-1:0]   od;
        logic [NL-1:0]   pol;
        logic [NL-1:0]   dir;
        logic [NL-1:0]   dat;
        logic [NL-1:0]   msk;
        logic [2*NL-1:0] sns;
        logic [7:0]      clk;
        logic [7:0]      misc;
        logic            armed;
    } state_t;

    localparam state_t RST_VAL = '{pu: '0, pd: '0, od: '0, pol: '0, dir: '1,
                                   dat: '0, msk: '1, sns: '0, clk: '0,
                                   misc: '0, armed: 1'b0};

    state_t st_d, st_q;
    logic [NL-1:0] pin_lvl;

    // byte b of a setting lives at base - b
    function automatic logic [NL-1:0] put1(input logic [NL-1:0] cur,
            input logic [7:0] base, input logic [7:0] a, input logic [7:0] d);
        logic [NL-1:0] r;
        r = cur;
        for (int b = 0; b < NB; b++)
            if (a == base - 8'(b)) r[8*b +: 8] = d;
        return r;
    endfunction

    function automatic logic [2*NL-1:0] put2(input logic [2*NL-1:0] cur,
            input logic [7:0] base, input logic [7:0] a, input logic [7:0] d);
        logic [2*NL-1:0] r;
        r = cur;
        for (int b = 0; b < NSB; b++)
            if (a == base - 8'(b)) r[8*b +: 8] = d;
        return r;
    endfunction

    function automatic logic [7:0] pick1(input logic [NL-1:0] v,
            input logic [7:0] base, input logic [7:0] a);
        logic [7:0] r;
        r = '0;
        for (int b = 0; b < NB; b++)
            if (a == base - 8'(b)) r = v[8*b +: 8];
        return r;
    endfunction

    function automatic logic [7:0] pick2(input logic [2*NL-1:0] v,
            input logic [7:0] base, input logic [7:0] a);
        logic [7:0] r;
        r = '0;
        for (int b = 0; b < NSB; b++)
            if (a == base - 8'(b)) r = v[8*b +: 8];
        return r;
    endfunction

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.armed = 1'b0;
            if (addr == A_RST) begin
                if (st_q.armed && wr_data == KEY_2) st_d = RST_VAL;
                else st_d.armed = (wr_data == KEY_1);
            end else begin
                st_d.pu  = put1(st_q.pu,  A_PU,  addr, wr_data);
                st_d.pd  = put1(st_q.pd,  A_PD,  addr, wr_data);
                st_d.od  = put1(st_q.od,  A_OD,  addr, wr_data);
                st_d.pol = put1(st_q.pol, A_POL, addr, wr_data);
                st_d.dir = put1(st_q.dir, A_DIR, addr, wr_data);
                st_d.dat = put1(st_q.dat, A_DAT, addr, wr_data);
                st_d.msk = put1(st_q.msk, A_MSK, addr, wr_data);
                st_d.sns = put2(st_q.sns, A_SNS, addr, wr_data);
                if (addr == A_CLK)  st_d.clk  = wr_data;
                if (addr == A_MISC) st_d.misc = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_VAL;
        else        st_q <= st_d;
    end

    assign pin_lvl = pin_sync ^ st_q.pol;

    always_comb begin
        rd_data = pick1(st_q.pu,  A_PU,  addr)
                | pick1(st_q.pd,  A_PD,  addr)
                | pick1(st_q.od,  A_OD,  addr)
                | pick1(st_q.pol, A_POL, addr)
                | pick1(st_q.dir, A_DIR, addr)
                | pick1(pin_lvl,  A_DAT, addr)
                | pick1(st_q.msk, A_MSK, addr)
                | pick2(st_q.sns, A_SNS, addr)
                | ((addr == A_CLK)  ? st_q.clk  : 8'h00)
                | ((addr == A_MISC) ? st_q.misc : 8'h00);
    end

    assign pu      = st_q.pu;
    assign pd      = st_q.pd;
    assign od      = st_q.od;
    assign pol     = st_q.pol;
    assign dir     = st_q.dir;
    assign dat     = st_q.dat;
    assign clk_cfg = st_q.clk;
endmodule

// File: rtl/gx_pad_drive.sv
module gx_pad_drive #(
    parameter int NL = 16
) (
    input  logic [NL-1:0] od,
    input  logic [NL-1:0] pol,
    input  logic [NL-1:0] dir,
    input  logic [NL-1:0] dat,
    input  logic [7:0]    clk_cfg,
    output logic [NL-1:0] pad_out,
    output logic [NL-1:0] pad_oe,
    output logic          osc_out,
    output logic          osc_oe
);
    for (genvar k = 0; k < NL; k++) begin : g_line
        logic lvl;
        assign lvl        = dat[k] ^ pol[k];
        assign pad_out[k] = lvl & ~od[k];
        assign pad_oe[k]  = ~dir[k] & ~(od[k] & lvl);
    end

    assign osc_oe  = clk_cfg[4];
    assign osc_out = clk_cfg[4] & (&clk_cfg[3:0]);
endmodule

// File: rtl/gx_regbank.sv
module gx_regbank #(
    parameter int NL          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    addr,
    input  logic [7:0]    wr_data,
    output logic [7:0]    rd_data,
    input  logic [NL-1:0] pad_in,
    output logic [NL-1:0] pad_out,
    output logic [NL-1:0] pad_oe,
    output logic [NL-1:0] pad_pu,
    output logic [NL-1:0] pad_pd,
    output logic          osc_out,
    output logic          osc_oe
);
    logic [NL-1:0] pin_sync, od, pol, dir, dat;
    logic [7:0]    clk_cfg;

    gx_sync #(.W(NL), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pin_sync)
    );

    gx_regfile #(.NL(NL)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .pin_sync(pin_sync), .rd_data(rd_data),
        .pu(pad_pu), .pd(pad_pd), .od(od), .pol(pol), .dir(dir),
        .dat(dat), .clk_cfg(clk_cfg)
    );

    gx_pad_drive #(.NL(NL)) drv_i (
        .od(od), .pol(pol), .dir(dir), .dat(dat), .clk_cfg(clk_cfg),
        .pad_out(pad_out), .pad_oe(pad_oe), .osc_out(osc_out), .osc_oe(osc_oe)
    );
endmodule

// File: rtl/gx_regbank_chk.sv
module gx_regbank_chk #(
    parameter int NL = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [7:0]    addr,
    input logic [7:0]    wr_data,
    input logic [7:0]    rd_data,
    input logic [NL-1:0] pad_oe,
    input logic          osc_out,
    input logic          osc_oe
);
    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en && addr == 8'h7D && wr_data == 8'h12)
         && wr_en && addr == 8'h7D && wr_data == 8'h34)
        |=> (pad_oe == '0 && !osc_oe)); // R9

    AST_OSC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h1E && wr_data == 8'h1F) |=> (osc_out && osc_oe)); // R8

    AST_OSC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h1E && wr_data == 8'h10) |=> (!osc_out && osc_oe)); // R8

    AST_DIR_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h0F && wr_data == 8'hFF) |=> (pad_oe[7:0] == 8'h00)); // R4

    AST_SRC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 8'h19 || addr == 8'h18 || addr == 8'h7D) |-> (rd_data == 8'h00)); // R11
endmodule

bind gx_regbank gx_regbank_chk #(.NL(NL)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .pad_oe(pad_oe), .osc_out(osc_out), .osc_oe(osc_oe)
);

// File: tb/gx_regbank_tb_top.sv
module gx_regbank_tb_top;
    localparam int NL = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    addr = 8'h00;
    logic [7:0]    wr_data = 8'h00;
    logic [7:0]    rd_data;
    logic [NL-1:0] pad_in = '0;
    logic [NL-1:0] pad_out, pad_oe, pad_pu, pad_pd;
    logic          osc_out, osc_oe;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gx_regbank #(.NL(NL), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pu(pad_pu), .pad_pd(pad_pd), .osc_out(osc_out), .osc_oe(osc_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        chk(tag, 32'(rd_data), 32'(exp));
    endtask

    task automatic t_reset();
        rd_chk("R1 dir lo", 8'h0F, 8'hFF);
        rd_chk("R1 dir hi", 8'h0E, 8'hFF);
        rd_chk("R1 mask lo", 8'h13, 8'hFF);
        rd_chk("R1 mask hi", 8'h12, 8'hFF);
        rd_chk("R1 pullup", 8'h07, 8'h00);
        rd_chk("R1 clock", 8'h1E, 8'h00);
        rd_chk("R1 sense", 8'h15, 8'h00);
        chk("R1 pad_oe", 32'(pad_oe), 32'h0);
        chk("R1 osc_oe", 32'(osc_oe), 32'h0);
    endtask

    task automatic t_layout();
        wr(8'h07, 8'h11); wr(8'h06, 8'h22);
        wr(8'h09, 8'h33); wr(8'h08, 8'h44);
        wr(8'h0B, 8'h55); wr(8'h0A, 8'h66);
        wr(8'h0D, 8'h77); wr(8'h0C, 8'h88);
        wr(8'h0F, 8'h99); wr(8'h0E, 8'hAA);
        wr(8'h13, 8'hBB); wr(8'h12, 8'hCC);
        wr(8'h1F, 8'h5A);
        rd_chk("R2 pu lo", 8'h07, 8'h11); rd_chk("R2 pu hi", 8'h06, 8'h22);
        rd_chk("R2 pd lo", 8'h09, 8'h33); rd_chk("R2 pd hi", 8'h08, 8'h44);
        rd_chk("R2 od lo", 8'h0B, 8'h55); rd_chk("R2 od hi", 8'h0A, 8'h66);
        rd_chk("R2 pol lo", 8'h0D, 8'h77); rd_chk("R2 pol hi", 8'h0C, 8'h88);
        rd_chk("R2 dir lo", 8'h0F, 8'h99); rd_chk("R2 dir hi", 8'h0E, 8'hAA);
        rd_chk("R2 msk lo", 8'h13, 8'hBB); rd_chk("R2 msk hi", 8'h12, 8'hCC);
        rd_chk("R2 misc", 8'h1F, 8'h5A);
        chk("R12 pad_pu", 32'(pad_pu), 32'h2211);
        chk("R12 pad_pd", 32'(pad_pd), 32'h4433);
        wr(8'h17, 8'hE4); wr(8'h16, 8'h1B); wr(8'h15, 8'hC3); wr(8'h14, 8'h3C);
        rd_chk("R3 sense lines 0-3", 8'h17, 8'hE4);
        rd_chk("R3 sense lines 4-7", 8'h16, 8'h1B);
        rd_chk("R3 sense lines 8-11", 8'h15, 8'hC3);
        rd_chk("R3 sense lines 12-15", 8'h14, 8'h3C);
    endtask

    task automatic t_softrst();
        wr(8'h7D, 8'h12); wr(8'h7D, 8'h34);
        rd_chk("R9 pu", 8'h07, 8'h00);
        rd_chk("R9 dir", 8'h0E, 8'hFF);
        rd_chk("R9 mask", 8'h13, 8'hFF);
        rd_chk("R9 sense", 8'h17, 8'h00);
        rd_chk("R9 misc", 8'h1F, 8'h00);
        chk("R9 pad_pu", 32'(pad_pu), 32'h0);
        chk("R9 pad_oe", 32'(pad_oe), 32'h0);
    endtask

    task automatic t_dir_data();
        wr(8'h0F, 8'h00); wr(8'h11, 8'hA5);
        chk("R4 pad_oe outputs", 32'(pad_oe), 32'h00FF);
        chk("R5 pad_out", 32'(pad_out), 32'h00A5);
        wr(8'h0D, 8'h0F);
        chk("R5 pad_out inverted", 32'(pad_out), 32'h00AA);
        wr(8'h0F, 8'hFF);
        chk("R4 pad_oe inputs", 32'(pad_oe), 32'h0000);
    endtask

    task automatic t_input();
        addr = 8'h11;
        @(negedge clk);
        pad_in = 16'h3C5A;
        @(posedge clk); #1;
        chk("R6 not yet after one edge", 32'(rd_data), 32'h0F);
        @(posedge clk); #1;
        chk("R6 visible after two edges", 32'(rd_data), 32'h55);
        rd_chk("R6 high byte", 8'h10, 8'h3C);
    endtask

    task automatic t_od();
        wr(8'h0D, 8'h00); wr(8'h0F, 8'h00); wr(8'h11, 8'h01); wr(8'h0B, 8'h03);
        chk("R7 open-drain oe", 32'(pad_oe), 32'h00FE);
        chk("R7 open-drain out", 32'(pad_out), 32'h0000);
        wr(8'h0B, 8'h00);
        chk("R7 push-pull oe", 32'(pad_oe), 32'h00FF);
        chk("R7 push-pull out", 32'(pad_out), 32'h0001);
    endtask

    task automatic t_clk();
        wr(8'h1E, 8'h1F);
        chk("R8 osc high out", 32'(osc_out), 32'h1);
        chk("R8 osc high oe", 32'(osc_oe), 32'h1);
        wr(8'h1E, 8'h10);
        chk("R8 osc low out", 32'(osc_out), 32'h0);
        chk("R8 osc low oe", 32'(osc_oe), 32'h1);
    endtask

    task automatic t_broken();
        wr(8'h07, 8'h55);
        wr(8'h7D, 8'h12); wr(8'h06, 8'h66); wr(8'h7D, 8'h34);
        rd_chk("R10 pu lo kept", 8'h07, 8'h55);
        rd_chk("R10 pu hi written", 8'h06, 8'h66);
        chk("R10 osc_oe kept", 32'(osc_oe), 32'h1);
    endtask

    task automatic t_unmapped();
        wr(8'h30, 8'hAA);
        rd_chk("R11 unmapped", 8'h30, 8'h00);
        rd_chk("R11 source lo", 8'h19, 8'h00);
        rd_chk("R11 source hi", 8'h18, 8'h00);
        rd_chk("R11 reset addr", 8'h7D, 8'h00);
        rd_chk("R11 pu untouched", 8'h07, 8'h55);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_softrst();
        t_dir_data();
        t_input();
        t_od();
        t_clk();
        t_broken();
        t_unmapped();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule